// File: doc/BRIEF.md
# Cascaded Dual-Notch Audio Filter

This block removes two fixed narrowband tones from a stream of signed 8-bit audio samples taken at 7.4 kHz. Two second-order recursive notch sections run back to back. The first section places its zeros on the unit circle at ±15.324° (315 Hz). The second places its zeros at ±121.62° (2500 Hz). In each section the conjugate poles sit at the same angle as the zeros, at radius 0.99, which keeps each notch narrow.

Each section forms y[n] = x[n] + a1·x[n-1] + x[n-2] + b1·y[n-1] + b2·y[n-2]. Both outer numerator taps are fixed at one, so every section needs only three constant multiplies and one five-term sum. This leaves the passband gain slightly above unity. The sum is rounded and clipped before it enters the feedback history. The final result is clipped to the 8-bit output range.

A sample is offered by pulsing `in_valid` for one cycle. The filtered sample appears two cycles later, marked by a one-cycle `out_valid` pulse. Cycles without `in_valid` leave all filter state untouched.

Top module: `dual_notch_filter`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_data` are 0 and every history register is zero. The first sample after reset is therefore filtered as if all earlier inputs and outputs were zero.
- R2: Every cycle in which `in_valid` is high produces exactly one `out_valid` pulse, one cycle wide, two rising edges later. `out_valid` is never high otherwise.
- R3: Each section computes x[n] + a1·x[n-1] + x[n-2] + b1·y[n-1] + b2·y[n-2] with signed Q2.14 constants (value / 16384). The first section uses a1 = -31603, b1 = 31287, b2 = -16058. The second uses a1 = 17180, b1 = -17009, b2 = -16058.
- R4: The full-precision section sum is rounded by adding 8192 (half an LSB of the 2^14 scale) and then shifting right arithmetically by 14.
- R5: The rounded section result is clipped to the signed range of the internal sample width (`SEC_W`) before it is stored as y[n-1] and passed on.
- R6: The cascade output is the last section's result clipped to the signed range [-128, 127].
- R7: Cycles with `in_valid` low change no history register. Any number of idle cycles between samples has no effect on later outputs.
- R8: The second section takes the first section's stored result as its x[n]. The first section takes `in_data`, sign-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe marking a new input sample |
| in_data | input | IN_W (8) | Signed input sample |
| out_valid | output | 1 | One-cycle strobe marking a filtered sample |
| out_data | output | OUT_W (8) | Signed filtered sample |

## Verification
The bench builds two copies side by side from the same stimulus. One uses the default internal width `SEC_W` = 16. At that width the internal sections never clip, and a full-scale alternating input pushes the cascade past +127 or -128, so the output clip is exercised. The other uses `SEC_W` = 8. At that width the first section's result exceeds the 8-bit internal range on the same alternating input, so section-level clipping feeds back into the recursion. Both copies are compared sample by sample against a bench model that applies the stated difference equation, rounding and clipping to each copy.

// File: rtl/dnf_pkg.sv
package dnf_pkg;

  localparam int NUM_SEC = 2;
  localparam int COEF_W  = 16;
  localparam int FRAC_W  = 14;

  typedef logic signed [COEF_W-1:0] coef_t;

  // Q2.14 constants, index 0 = 315 Hz notch, index 1 = 2500 Hz notch
  localparam coef_t ZERO_TAP [NUM_SEC] = '{-16'sd31603,  16'sd17180};
  localparam coef_t POLE_TAP1[NUM_SEC] = '{ 16'sd31287, -16'sd17009};
  localparam coef_t POLE_TAP2[NUM_SEC] = '{-16'sd16058, -16'sd16058};

endpackage

// File: rtl/dnf_sat.sv
module dnf_sat #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  in_v,
  output logic signed [OUT_W-1:0] out_v
);

  localparam int HEAD_W = IN_W - OUT_W + 1;

  logic [HEAD_W-1:0] head;
  logic              fits;

  always_comb begin
    head = in_v[IN_W-1:OUT_W-1];
    fits = (head == '0) || (head == '1);
    if (fits) begin
      out_v = in_v[OUT_W-1:0];
    end else if (in_v[IN_W-1]) begin
      out_v = {1'b1, {(OUT_W-1){1'b0}}};
    end else begin
      out_v = {1'b0, {(OUT_W-1){1'b1}}};
    end
  end

endmodule

// File: rtl/dnf_section.sv
module dnf_section
  import dnf_pkg::*;
#(
  parameter int                       SMP_W = 16,
  parameter int                       CW    = COEF_W,
  parameter int                       FW    = FRAC_W,
  parameter logic signed [CW-1:0]     K_A1  = '0,
  parameter logic signed [CW-1:0]     K_B1  = '0,
  parameter logic signed [CW-1:0]     K_B2  = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic signed [SMP_W-1:0] in_x,
  output logic                    out_vld,
  output logic signed [SMP_W-1:0] out_y
);

  localparam int ACC_W = SMP_W + CW + 3;
  localparam logic signed [ACC_W-1:0] HALF  = ACC_W'(1) <<< (FW - 1);
  localparam logic signed [ACC_W-1:0] Y_MAX = (ACC_W'(1) <<< (SMP_W - 1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] Y_MIN = -(ACC_W'(1) <<< (SMP_W - 1));

  // history registers
  logic signed [SMP_W-1:0] x1_q, x2_q, y1_q, y2_q;
  logic signed [SMP_W-1:0] x1_d, x2_d, y1_d, y2_d;
  logic                    vld_q, vld_d;

  // datapath
  logic signed [ACC_W-1:0] t_x0, t_x2, t_a1, t_b1, t_b2;
  logic signed [ACC_W-1:0] acc, sum_sh;
  logic signed [SMP_W-1:0] y_new;

  always_comb begin
    t_x0   = ACC_W'(in_x) <<< FW;
    t_x2   = ACC_W'(x2_q) <<< FW;
    t_a1   = ACC_W'(K_A1) * ACC_W'(x1_q);
    t_b1   = ACC_W'(K_B1) * ACC_W'(y1_q);
    t_b2   = ACC_W'(K_B2) * ACC_W'(y2_q);
    acc    = t_x0 + t_a1 + t_x2 + t_b1 + t_b2;
    sum_sh = (acc + HALF) >>> FW;
  end

  dnf_sat #(
    .IN_W  (ACC_W),
    .OUT_W (SMP_W)
  ) u_sat (
    .in_v  (sum_sh),
    .out_v (y_new)
  );

  // next-state
  always_comb begin
    vld_d = in_vld;
    x1_d  = in_x;
    x2_d  = x1_q;
    y1_d  = y_new;
    y2_d  = y1_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      x1_q  <= '0;
      x2_q  <= '0;
      y1_q  <= '0;
      y2_q  <= '0;
    end else begin
      vld_q <= vld_d;
      if (in_vld) begin
        x1_q <= x1_d;
        x2_q <= x2_d;
        y1_q <= y1_d;
        y2_q <= y2_d;
      end
    end
  end

  assign out_vld = vld_q;
  assign out_y   = y1_q;

  // R7: history frozen on idle cycles
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(x1_q) && $stable(x2_q) && $stable(y1_q) && $stable(y2_q)));

  // R3: all-zero state with zero input stays at zero
  p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_x == '0 && x1_q == '0 && x2_q == '0 && y1_q == '0 && y2_q == '0)
      |=> (out_y == '0));

  // R5: clipping of the rounded sum
  p_sat_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && sum_sh > Y_MAX) |=> (out_y == Y_MAX[SMP_W-1:0]));

  p_sat_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && sum_sh < Y_MIN) |=> (out_y == Y_MIN[SMP_W-1:0]));

  // R2: one registered stage per section
  p_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld));

endmodule

// File: rtl/dual_notch_filter.sv
module dual_notch_filter
  import dnf_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 8,
  parameter int SEC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);

  localparam logic signed [SEC_W-1:0] O_MAX = (SEC_W'(1) <<< (OUT_W - 1)) - SEC_W'(1);
  localparam logic signed [SEC_W-1:0] O_MIN = -(SEC_W'(1) <<< (OUT_W - 1));

  logic signed [SEC_W-1:0] stage_y [NUM_SEC+1];
  logic                    stage_v [NUM_SEC+1];

  assign stage_y[0] = SEC_W'(in_data);
  assign stage_v[0] = in_valid;

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    dnf_section #(
      .SMP_W (SEC_W),
      .K_A1  (ZERO_TAP[s]),
      .K_B1  (POLE_TAP1[s]),
      .K_B2  (POLE_TAP2[s])
    ) u_sec (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (stage_v[s]),
      .in_x    (stage_y[s]),
      .out_vld (stage_v[s+1]),
      .out_y   (stage_y[s+1])
    );
  end

  dnf_sat #(
    .IN_W  (SEC_W),
    .OUT_W (OUT_W)
  ) u_out_sat (
    .in_v  (stage_y[NUM_SEC]),
    .out_v (out_data)
  );

  assign out_valid = stage_v[NUM_SEC];

  // R2: fixed two-cycle latency, no stray strobes
  p_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  p_no_extra_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  // R6: output clip against last section result
  p_clip_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_y[NUM_SEC] > O_MAX) |-> (out_data == O_MAX[OUT_W-1:0]));

  p_clip_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_y[NUM_SEC] < O_MIN) |-> (out_data == O_MIN[OUT_W-1:0]));

endmodule

// File: tb/test_dual_notch_filter.sv
`timescale 1ns/1ps
module test_dual_notch_filter;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic signed [7:0] in_data;
  logic              out_valid, out_valid_n;
  logic signed [7:0] out_data, out_data_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dual_notch_filter i_dual_notch_filter (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data),
    .out_valid (out_valid), .out_data (out_data)
  );

  dual_notch_filter #(.SEC_W(8)) i_dual_notch_filter_narrow (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data),
    .out_valid (out_valid_n), .out_data (out_data_n)
  );

  // bench model, built from R3..R8
  localparam longint KA1[2] = '{-31603, 17180};
  localparam longint KB1[2] = '{ 31287, -17009};
  localparam longint KB2[2] = '{-16058, -16058};
  localparam int     WID[2] = '{16, 8};

  longint hx1[2][2], hx2[2][2], hy1[2][2], hy2[2][2];

  localparam int NSTIM = 32;
  localparam int STIM[NSTIM] = '{
    64, 0, 0, 0, 0, 0,
    127, 127, 127, 127, 127, 127,
    -128, -128, -128, -128,
    127, -128, 127, -128, 127, -128, 127, -128, 127, -128, 127, -128,
    30, -75, 12, -3};

  function automatic longint clipw(longint v, int w);
    longint mx = (longint'(1) <<< (w - 1)) - 1;
    longint mn = -mx - 1;
    if (v > mx) return mx;
    if (v < mn) return mn;
    return v;
  endfunction

  task automatic model_clear();
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 2; s++) begin
        hx1[m][s] = 0; hx2[m][s] = 0; hy1[m][s] = 0; hy2[m][s] = 0;
      end
  endtask

  task automatic model_step(int m, longint x, output longint y);
    longint v, acc, r;
    v = x;
    for (int s = 0; s < 2; s++) begin
      acc = (v <<< 14) + (hx2[m][s] <<< 14) + KA1[s] * hx1[m][s]
          + KB1[s] * hy1[m][s] + KB2[s] * hy2[m][s];
      r = clipw((acc + 8192) >>> 14, WID[m]);
      hx2[m][s] = hx1[m][s]; hx1[m][s] = v;
      hy2[m][s] = hy1[m][s]; hy1[m][s] = r;
      v = r;
    end
    y = clipw(v, 8);
  endtask

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string tag_of(int i);
    if (i < 6)  return "R4";
    if (i < 12) return "R8";
    if (i < 16) return "R3";
    if (i < 28) return "R5/R6";
    return "R7";
  endfunction

  task automatic send(longint x, string tag, int gap);
    longint ew, en;
    model_step(0, x, ew);
    model_step(1, x, en);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'(x);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = '0;
    chk("R2 early valid", out_valid, 0);
    @(negedge clk);
    chk("R2 valid", out_valid, 1);
    chk("R2 valid narrow", out_valid_n, 1);
    chk({tag, " data"}, out_data, ew);
    chk({tag, " data narrow"}, out_data_n, en);
    @(negedge clk);
    chk("R2 pulse width", out_valid, 0);
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    model_clear();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", out_valid, 0);
    chk("R1 data", out_data, 0);
    chk("R1 data narrow", out_data_n, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NSTIM; i++) send(STIM[i], tag_of(i), 0);

    // R7: long idle gap then more samples
    repeat (25) @(negedge clk);
    send(-90, "R7", 7);
    send(45, "R7", 0);

    // R1: reset mid-stream clears history
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 valid in reset", out_valid, 0);
    chk("R1 data in reset", out_data, 0);
    rst_n = 1'b1;
    model_clear();
    send(100, "R1", 0);
    send(0, "R1", 0);
    send(0, "R1", 0);

    // R6: full-scale alternating burst after reset
    for (int i = 0; i < 16; i++) send((i % 2 == 0) ? 127 : -128, "R6", 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule